// File: doc/BRIEF.md
# Indexed Widening Multiply-Accumulate Lane Array

This block is one vector step of a widening multiply-accumulate. It takes three vectors of `VEC_BITS` bits each. The first holds unsigned 16-bit values. The second supplies a multiplier operand. The third holds 32-bit accumulator lanes.

The second vector is split into 128-bit segments. A 3-bit index picks one 16-bit position, and that same position is used in every segment. The value found there is broadcast to the four 32-bit lanes that share the segment.

Each 32-bit lane covers two adjacent 16-bit values of the first vector. A parity input chooses which of the two feeds the lane: the lower (even-numbered) one or the upper (odd-numbered) one. The chosen value is multiplied by the broadcast value and the product is added to the lane's accumulator value.

A caller fills a register pair by issuing the step twice, once with each parity. The caller owns the vector registers, decode and sequencing. This block only forms the updated accumulator vector. It registers that vector and raises a done pulse one cycle after a start.

Top module: `wmac_lane_array`

## Requirements
- R1: Result lane e (bits 32e+31..32e) equals accumulator lane e plus the product of two unsigned 16-bit operands. The product is zero-extended to 32 bits.
- R2: The multiplier operand for lane e is 16-bit element number 8*(e div 4) + idx_i of src_b_i, which occupies bits 16k+15..16k for element number k. idx_i is 3 bits wide and takes values 0 to 7.
- R3: The multiplicand for lane e is 16-bit element 2e + parity_i of src_a_i. parity_i = 0 selects the even element and parity_i = 1 the odd element.
- R4: The addition wraps modulo 2^32 with no saturation. For example, 0xFFFF * 0xFFFF added to 0xFFFFFFFF gives 0xFFFE0000.
- R5: Every one of the VEC_BITS/32 lanes is written on each start, with no masking.
- R6: The updated vector appears on result_o, and done_o is 1, in the first cycle after the clock edge that samples start_i = 1.
- R7: done_o is 0 after any edge that samples start_i = 0, and result_o then keeps its previous value.
- R8: A synchronous active-low reset clears result_o to zero and done_o to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Perform one accumulate step this cycle |
| parity_i | input | 1 | 0: even source elements, 1: odd source elements |
| idx_i | input | 3 | Element position within each 128-bit segment of src_b_i |
| src_a_i | input | VEC_BITS | Unsigned 16-bit multiplicand elements |
| src_b_i | input | VEC_BITS | Vector holding the indexed multiplier elements |
| acc_i | input | VEC_BITS | 32-bit accumulator lanes |
| result_o | output | VEC_BITS | Registered updated accumulator lanes |
| done_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The hardest case to reach is telling apart lanes that share a segment from lanes in different segments. An index error that lands in the wrong segment can only be seen if the segments hold different data at the selected position. The bench therefore fills src_b_i so that every 16-bit element is distinct. It then sweeps all eight index values for both parities, so that a lane that reads the wrong segment, position or half shows a changed product. Wrap-around is reached with all-ones operands and accumulators, which pushes every lane past 2^32 at once.

// File: rtl/wmac_pkg.sv
// Shared widths and types for the widening multiply-accumulate lane array.
// Assumes 16-bit narrow elements, 32-bit wide lanes and 128-bit segments.
package wmac_pkg;
    localparam int NARROW_W      = 16;
    localparam int WIDE_W        = 32;
    localparam int SEG_W         = 128;
    localparam int NARROW_PER_SEG = SEG_W / NARROW_W;
    localparam int LANES_PER_SEG = SEG_W / WIDE_W;
    localparam int IDX_W         = $clog2(NARROW_PER_SEG);

    typedef logic [NARROW_W-1:0] narrow_t;
    typedef logic [WIDE_W-1:0]   wide_t;
endpackage

// File: rtl/wmac_seg_bcast.sv
// Picks one 16-bit element out of a 128-bit segment by index.
// The chosen value is broadcast to every lane of that segment.
// Assumes idx_i always lies in range (3 bits cover exactly 8 positions).
module wmac_seg_bcast
    import wmac_pkg::*;
(
    input  logic [SEG_W-1:0] seg_i,
    input  logic [IDX_W-1:0] idx_i,
    output narrow_t          elem_o
);
    // Index mux over the eight narrow positions of the segment.
    always_comb begin
        elem_o = '0;
        for (int k = 0; k < NARROW_PER_SEG; k++) begin
            if (idx_i == IDX_W'(k)) begin
                elem_o = seg_i[k*NARROW_W +: NARROW_W];
            end
        end
    end
endmodule

// File: rtl/wmac_lane.sv
// One 32-bit lane: selects the even or odd narrow element of its pair,
// multiplies it by the broadcast operand and adds the accumulator value.
// Assumes unsigned operands; the sum wraps modulo 2^32.
module wmac_lane
    import wmac_pkg::*;
(
    input  wide_t   pair_i,
    input  logic    parity_i,
    input  narrow_t mult_i,
    input  wide_t   acc_i,
    output wide_t   sum_o
);
    narrow_t sel_elem;
    wide_t   product;

    // Parity picks the low (even) or high (odd) half of the pair.
    always_comb begin
        sel_elem = parity_i ? pair_i[WIDE_W-1:NARROW_W] : pair_i[NARROW_W-1:0];
    end

    // Widen, multiply and accumulate with natural 32-bit wrap.
    always_comb begin
        product = wide_t'(sel_elem) * wide_t'(mult_i);
        sum_o   = acc_i + product;
    end
endmodule

// File: rtl/wmac_out_reg.sv
// Result register with done pulse. Loads on start, otherwise holds.
// Synchronous active-low reset clears both the data and the pulse.
module wmac_out_reg #(
    parameter int DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              done_o
);
    // Capture the new vector when a step is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
        end else if (load_i) begin
            data_o <= data_i;
        end
    end

    // Pulse done for exactly the cycle after each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
        end else begin
            done_o <= load_i;
        end
    end
endmodule

// File: rtl/wmac_lane_array.sv
// Top of the indexed widening multiply-accumulate lane array.
// Builds one broadcast selector per 128-bit segment and one lane per 32 bits,
// then registers the whole vector. Assumes VEC_BITS is a multiple of 128.
module wmac_lane_array
    import wmac_pkg::*;
#(
    parameter int VEC_BITS = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                parity_i,
    input  logic [2:0]          idx_i,
    input  logic [VEC_BITS-1:0] src_a_i,
    input  logic [VEC_BITS-1:0] src_b_i,
    input  logic [VEC_BITS-1:0] acc_i,
    output logic [VEC_BITS-1:0] result_o,
    output logic                done_o
);
    localparam int NUM_SEG   = VEC_BITS / SEG_W;
    localparam int NUM_LANES = VEC_BITS / WIDE_W;

    narrow_t             seg_mult [NUM_SEG];
    logic [VEC_BITS-1:0] next_vec;

    // One index selector per segment.
    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        wmac_seg_bcast u_bcast (
            .seg_i  (src_b_i[s*SEG_W +: SEG_W]),
            .idx_i  (idx_i),
            .elem_o (seg_mult[s])
        );
    end

    // One multiply-accumulate lane per 32 bits, fed by its segment's operand.
    for (genvar e = 0; e < NUM_LANES; e++) begin : g_lane
        wmac_lane u_lane (
            .pair_i   (src_a_i[e*WIDE_W +: WIDE_W]),
            .parity_i (parity_i),
            .mult_i   (seg_mult[e / LANES_PER_SEG]),
            .acc_i    (acc_i[e*WIDE_W +: WIDE_W]),
            .sum_o    (next_vec[e*WIDE_W +: WIDE_W])
        );
    end

    wmac_out_reg #(.DATA_W(VEC_BITS)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (start_i),
        .data_i (next_vec),
        .data_o (result_o),
        .done_o (done_o)
    );
endmodule

// File: rtl/wmac_lane_array_chk.sv
// Property checker for wmac_lane_array, attached by bind below.
// Watches the handshake, hold behaviour, reset and the arithmetic of lane 0.
module wmac_lane_array_chk #(
    parameter int VEC_BITS = 256
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                parity_i,
    input logic [2:0]          idx_i,
    input logic [31:0]         a_lane0_i,
    input logic [127:0]        b_seg0_i,
    input logic [31:0]         acc_lane0_i,
    input logic [VEC_BITS-1:0] result_o,
    input logic                done_o
);
    logic [31:0] lane0_exp;

    // Lane 0 expectation from the element numbering in the requirements.
    always_comb begin
        lane0_exp = acc_lane0_i
                  + ({16'b0, a_lane0_i[16*parity_i +: 16]} * {16'b0, b_seg0_i[16*idx_i +: 16]});
    end

    assert_done_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    assert_done_low_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(result_o));

    assert_lane0_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> result_o[31:0] == $past(lane0_exp));

    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (!done_o && result_o == '0));
endmodule

bind wmac_lane_array wmac_lane_array_chk #(.VEC_BITS(VEC_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .parity_i    (parity_i),
    .idx_i       (idx_i),
    .a_lane0_i   (src_a_i[31:0]),
    .b_seg0_i    (src_b_i[127:0]),
    .acc_lane0_i (acc_i[31:0]),
    .result_o    (result_o),
    .done_o      (done_o)
);

// File: tb/wmac_lane_array_tb.sv
`timescale 1ns/1ps
module wmac_lane_array_tb;
    localparam int VL    = 256;
    localparam int LANES = VL / 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          parity_i = 1'b0;
    logic [2:0]    idx_i = '0;
    logic [VL-1:0] src_a_i = '0;
    logic [VL-1:0] src_b_i = '0;
    logic [VL-1:0] acc_i = '0;
    logic [VL-1:0] result_o;
    logic          done_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    wmac_lane_array #(.VEC_BITS(VL)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .parity_i(parity_i),
        .idx_i(idx_i), .src_a_i(src_a_i), .src_b_i(src_b_i), .acc_i(acc_i),
        .result_o(result_o), .done_o(done_o)
    );

    // Reference from the requirement text: lane e uses a[2e+p] and b[8*(e/4)+idx].
    function automatic logic [VL-1:0] model(input logic [VL-1:0] a, input logic [VL-1:0] b,
                                            input logic [VL-1:0] acc, input logic [2:0] idx,
                                            input logic p);
        logic [VL-1:0] r;
        for (int e = 0; e < LANES; e++) begin
            logic [31:0] ae, be;
            ae = {16'b0, a[16*(2*e + int'(p)) +: 16]};
            be = {16'b0, b[16*(8*(e/4) + int'(idx)) +: 16]};
            r[32*e +: 32] = acc[32*e +: 32] + ae * be;
        end
        return r;
    endfunction

    function automatic logic [VL-1:0] rand_vec();
        logic [VL-1:0] v;
        for (int i = 0; i < VL/32; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    task automatic check_vec(input string req, input logic [VL-1:0] act, input logic [VL-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: result actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: done actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive one step at a falling edge; check at the falling edge after the capture edge.
    task automatic step(input string req, input logic [VL-1:0] a, input logic [VL-1:0] b,
                        input logic [VL-1:0] acc, input logic [2:0] idx, input logic p);
        src_a_i = a; src_b_i = b; acc_i = acc; idx_i = idx; parity_i = p;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check_vec(req, result_o, model(a, b, acc, idx, p));
        check_bit(req, done_o, 1'b1);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_vec("R8", result_o, '0);
        check_bit("R8", done_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_basic();
        // R1, R5: random data, every lane compared.
        for (int t = 0; t < 6; t++) begin
            step("R1_R5", rand_vec(), rand_vec(), rand_vec(), 3'($urandom), 1'($urandom));
        end
    endtask

    task automatic test_index_sweep();
        // R2: distinct element values so any wrong segment or position shows.
        logic [VL-1:0] b;
        for (int k = 0; k < VL/16; k++) b[16*k +: 16] = 16'(k * 37 + 5);
        for (int i = 0; i < 8; i++) begin
            step("R2", rand_vec(), b, rand_vec(), 3'(i), 1'b0);
            step("R2", rand_vec(), b, rand_vec(), 3'(i), 1'b1);
        end
    endtask

    task automatic test_parity();
        // R3: even halves 1, odd halves 2, multiplier 3, acc 0: lanes read 3 or 6.
        logic [VL-1:0] a, b, exp;
        for (int k = 0; k < VL/16; k++) begin
            a[16*k +: 16] = (k % 2 == 0) ? 16'd1 : 16'd2;
            b[16*k +: 16] = 16'd3;
        end
        for (int e = 0; e < LANES; e++) exp[32*e +: 32] = 32'd3;
        step("R3", a, b, '0, 3'd4, 1'b0);
        check_vec("R3", result_o, exp);
        for (int e = 0; e < LANES; e++) exp[32*e +: 32] = 32'd6;
        step("R3", a, b, '0, 3'd4, 1'b1);
        check_vec("R3", result_o, exp);
    endtask

    task automatic test_wrap();
        // R4: 0xFFFF*0xFFFF + 0xFFFFFFFF wraps to 0xFFFE0000 in every lane.
        logic [VL-1:0] exp;
        for (int e = 0; e < LANES; e++) exp[32*e +: 32] = 32'hFFFE_0000;
        step("R4", '1, '1, '1, 3'd7, 1'b1);
        check_vec("R4", result_o, exp);
    endtask

    task automatic test_hold();
        // R6, R7: pulse lasts one cycle, result holds while inputs change.
        logic [VL-1:0] a, b, acc, held;
        a = rand_vec(); b = rand_vec(); acc = rand_vec();
        step("R6", a, b, acc, 3'd2, 1'b0);
        held = model(a, b, acc, 3'd2, 1'b0);
        src_a_i = rand_vec(); src_b_i = rand_vec(); acc_i = rand_vec(); parity_i = 1'b1;
        @(negedge clk);
        check_bit("R7", done_o, 1'b0);
        check_vec("R7", result_o, held);
        @(negedge clk);
        check_vec("R7", result_o, held);
        step("R6", a, b, acc, 3'd5, 1'b1);
        step("R6", acc, a, b, 3'd1, 1'b0);
        @(negedge clk);
        check_bit("R7", done_o, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        test_reset();
        test_basic();
        test_index_sweep();
        test_parity();
        test_wrap();
        test_hold();
        test_reset();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule